// File: doc/BRIEF.md
# Manchester Bi-Phase Word Transmitter

This block turns one 16-bit word into a serial frame for a 1 Mbps command/response bus. It is clocked at 2 MHz, so every bit time takes two clock cycles and the serial output carries one half-bit per cycle. A frame always lasts 20 bit times (40 cycles). It has three parts:

- a 3-bit-time sync pattern with no transition in the middle of a bit;
- the sixteen data bits, each Manchester coded;
- one odd-parity bit.

A one-bit select chooses the sync shape for each word: one shape marks a command or status word, the inverse shape marks a data word.

A higher-level controller places the word and the sync select on the inputs and raises the start strobe for one cycle. The block captures both on that edge. It then drives the serial line together with a transmit-enable, which keys an external line driver. After the last half-bit it lowers the enable and raises a one-cycle done pulse. Start strobes that arrive while a frame is on the line are ignored.

Top module: `mbp_word_tx`

## Requirements
- R1: After an accepted start, `tx_en_o` is high for exactly 40 consecutive cycles. Its first high cycle is the cycle after the accepting clock edge.
- R2: The first 6 enabled cycles carry the sync pattern.
  - With `sync_is_data_i` = 0 (command/status sync), the line is high for 3 cycles, then low for 3 cycles.
  - With `sync_is_data_i` = 1 (data sync), the line is low for 3 cycles, then high for 3 cycles.
- R3: Enabled cycles 7 to 38 carry the data bits most significant bit first, two cycles per bit. Word bit i occupies cycles 7+2*(15-i) and 8+2*(15-i).
  - A 1 is sent as high then low.
  - A 0 is sent as low then high.
- R4: Enabled cycles 39 and 40 carry a parity bit, coded like a data bit. The parity bit makes the count of ones over the 16 data bits plus the parity bit odd.
- R5: `done_o` is high for exactly one cycle. That cycle is the first cycle after the last half-bit, the same cycle in which `tx_en_o` is first low again.
- R6: A start strobe seen while `tx_en_o` is high is ignored, including in the last enabled cycle. The frame in progress keeps its content and its 40-cycle length.
- R7: Outside a frame, and after a synchronous active-high reset, `tx_line_o`, `tx_en_o` and `done_o` are all low.
- R8: The word and the sync select are sampled only on the accepting edge. Changes to them during a frame do not alter that frame.
- R9: A start is accepted in any cycle where `tx_en_o` is low, including the cycle in which `done_o` is high. A frame started there follows the previous one with a one-cycle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; accepted when no frame is running |
| word_i | input | 16 | Word to send, sampled on the accepting edge |
| sync_is_data_i | input | 1 | 0 selects command/status sync, 1 selects data sync |
| tx_line_o | output | 1 | Registered serial half-bit output |
| tx_en_o | output | 1 | Registered transmit enable, high during the 40 frame cycles |
| done_o | output | 1 | One-cycle pulse after the last half-bit |

## Verification
The bench builds the block with its default values: a 16-bit word and a 3-bit-time sync, which gives the 40-cycle frame that the requirements count in. These values allow every half-bit position of a frame to be compared against a model that is computed independently. Words with alternating bits, all zeros, all ones and both parity outcomes are sent. Start strobes are injected in the middle of a frame and on its last cycle, and a second frame is launched on the done cycle.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    localparam int WORD_W_DEF    = 16;
    localparam int SYNC_BITS_DEF = 3;

    typedef enum logic {
        SYNC_CMD  = 1'b0,
        SYNC_DATA = 1'b1
    } sync_kind_e;

    // Cycles in one frame: two half-bits per bit time (sync + data + parity).
    function automatic int frame_cycles(input int data_w, input int sync_bits);
        return 2 * (sync_bits + data_w + 1);
    endfunction

    // Odd parity bit: set when the word holds an even number of ones.
    function automatic logic odd_parity16(input logic [15:0] w);
        return ~(^w);
    endfunction

endpackage

// File: rtl/mbp_seq.sv
module mbp_seq #(
    parameter int FRAME_CYC = 40,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             fin
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYC);

    assign load = start & ~busy;
    assign fin  = busy & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(1);
        end else if (fin) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/mbp_halfgen.sv
module mbp_halfgen
    import mbp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SYNC_BITS = 3,
    parameter int IDX_W     = 6
) (
    input  logic [DATA_W-1:0] word,
    input  sync_kind_e        sync,
    input  logic [IDX_W-1:0]  idx,
    output logic              level
);

    localparam int SYNC_CYC = 2 * SYNC_BITS;
    localparam int BSEL_W   = $clog2(DATA_W + 1);

    logic [DATA_W:0]  payload;   // data bits then parity, LSB = parity
    logic [DATA_W:0]  msb_first; // index 0 = first bit sent
    logic [IDX_W-1:0] rel;
    logic [BSEL_W-1:0] bsel;
    logic             bit_val;

    assign payload = {word, ~(^word)};

    for (genvar g = 0; g <= DATA_W; g++) begin : g_order
        assign msb_first[g] = payload[DATA_W - g];
    end

    assign rel     = idx - IDX_W'(SYNC_CYC);
    assign bsel    = rel[BSEL_W:1];
    assign bit_val = msb_first[bsel];

    always_comb begin
        if (idx < IDX_W'(SYNC_BITS)) begin
            level = (sync == SYNC_CMD);
        end else if (idx < IDX_W'(SYNC_CYC)) begin
            level = (sync == SYNC_DATA);
        end else begin
            level = rel[0] ? ~bit_val : bit_val;
        end
    end

endmodule

// File: rtl/mbp_word_tx.sv
module mbp_word_tx
    import mbp_pkg::*;
#(
    parameter int DATA_W    = WORD_W_DEF,
    parameter int SYNC_BITS = SYNC_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              sync_is_data_i,
    output logic              tx_line_o,
    output logic              tx_en_o,
    output logic              done_o
);

    localparam int FRAME_CYC = frame_cycles(DATA_W, SYNC_BITS);
    localparam int CNT_W     = $clog2(FRAME_CYC + 1);

    logic              busy, load, fin;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] word_q, word_src;
    sync_kind_e        sync_q, sync_src;
    logic [CNT_W-1:0]  idx;
    logic              level;
    logic              line_q, done_q;

    mbp_seq #(
        .FRAME_CYC(FRAME_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .start(start_i),
        .busy (busy),
        .cnt  (cnt),
        .load (load),
        .fin  (fin)
    );

    // On the accepting edge the first half-bit comes straight from the inputs.
    assign word_src = busy ? word_q : word_i;
    assign sync_src = busy ? sync_q : sync_kind_e'(sync_is_data_i);
    assign idx      = busy ? cnt : '0;

    mbp_halfgen #(
        .DATA_W   (DATA_W),
        .SYNC_BITS(SYNC_BITS),
        .IDX_W    (CNT_W)
    ) u_gen (
        .word (word_src),
        .sync (sync_src),
        .idx  (idx),
        .level(level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            sync_q <= SYNC_CMD;
            line_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (load) begin
                word_q <= word_i;
                sync_q <= sync_kind_e'(sync_is_data_i);
            end
            line_q <= (load || (busy && !fin)) ? level : 1'b0;
            done_q <= fin;
        end
    end

    assign tx_line_o = line_q;
    assign tx_en_o   = busy;
    assign done_o    = done_q;

endmodule

// File: rtl/mbp_word_tx_chk.sv
module mbp_word_tx_chk #(
    parameter int DATA_W    = 16,
    parameter int SYNC_BITS = 3
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic tx_line,
    input logic tx_en,
    input logic done
);

    localparam int FRAME_CYC = 2 * (SYNC_BITS + DATA_W + 1);
    localparam int N_W       = $clog2(FRAME_CYC + 2);

    // Number of enabled cycles already seen in the current frame.
    logic [N_W-1:0] n;

    always_ff @(posedge clk) begin
        if (rst)        n <= '0;
        else if (tx_en) n <= n + N_W'(1);
        else            n <= '0;
    end

    AST_FRAME_LEN_END: assert property (@(posedge clk) disable iff (rst)
        (tx_en && n == N_W'(FRAME_CYC - 1)) |=> !tx_en); // R1
    AST_FRAME_LEN_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |-> (n == N_W'(FRAME_CYC))); // R1
    AST_SYNC_FLAT: assert property (@(posedge clk) disable iff (rst)
        (tx_en && n >= N_W'(1) && n < N_W'(2 * SYNC_BITS) && n != N_W'(SYNC_BITS))
        |-> (tx_line == $past(tx_line))); // R2
    AST_SYNC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tx_en && n == N_W'(SYNC_BITS)) |-> (tx_line != $past(tx_line))); // R2
    AST_MID_BIT_FLIP: assert property (@(posedge clk) disable iff (rst)
        (tx_en && n >= N_W'(2 * SYNC_BITS + 1) && n[0])
        |-> (tx_line != $past(tx_line))); // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !tx_line); // R7
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_en && $past(tx_en))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past(start)); // R9

endmodule

bind mbp_word_tx mbp_word_tx_chk #(
    .DATA_W   (DATA_W),
    .SYNC_BITS(SYNC_BITS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start_i),
    .tx_line(tx_line_o),
    .tx_en  (tx_en_o),
    .done   (done_o)
);

// File: tb/sim_mbp_word_tx.sv
`timescale 1ns/1ps
module sim_mbp_word_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        sync_is_data_i = 1'b0;
    logic        tx_line_o, tx_en_o, done_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    mbp_word_tx u0 (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .word_i        (word_i),
        .sync_is_data_i(sync_is_data_i),
        .tx_line_o     (tx_line_o),
        .tx_en_o       (tx_en_o),
        .done_o        (done_o)
    );

    // Expected level of half-bit h (0..39), computed from R2..R4.
    function automatic logic exp_half(input logic [15:0] w, input logic sel, input int h);
        logic d;
        int j, b;
        if (h < 3) return !sel;
        if (h < 6) return sel;
        j = h - 6;
        b = j / 2;
        d = (b < 16) ? w[15 - b] : ~(^w);
        return (j % 2 == 1) ? !d : d;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Caller is at a negedge; raise start for one edge.
    task automatic launch(input logic [15:0] w, input logic sel);
        word_i = w;
        sync_is_data_i = sel;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Collect a frame that has just begun; poke = half index to inject start, -1 none.
    task automatic collect(input logic [15:0] w, input logic sel, input int poke,
                           input bit chain, input logic [15:0] w2, input logic sel2);
        logic [39:0] got_line, exp_line, got_en;
        for (int i = 0; i < 40; i++) begin
            got_line[i] = tx_line_o;
            got_en[i]   = tx_en_o;
            exp_line[i] = exp_half(w, sel, i);
            start_i = 1'b0;
            if (i == poke) begin
                start_i = 1'b1;
                word_i = ~w;
                sync_is_data_i = !sel;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(got_en == '1, "R1", "enable high 40 cycles", got_en, {40{1'b1}});
        check(got_line[5:0] == exp_line[5:0], "R2", "sync halves",
              got_line[5:0], exp_line[5:0]);
        check(got_line[37:6] == exp_line[37:6], "R3", "data halves",
              got_line[37:6], exp_line[37:6]);
        check(got_line[39:38] == exp_line[39:38], "R4", "parity halves",
              got_line[39:38], exp_line[39:38]);
        if (poke >= 0)
            check(got_line == exp_line && got_en == '1, "R6_R8", "frame after ignored start",
                  got_line, exp_line);
        check(!tx_en_o && done_o, "R5", "done with enable low",
              {tx_en_o, done_o}, 2'b01);
        if (chain) begin
            word_i = w2;
            sync_is_data_i = sel2;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(tx_en_o && !done_o && tx_line_o == exp_half(w2, sel2, 0), "R9",
                  "start on done cycle", {tx_en_o, done_o, tx_line_o},
                  {2'b10, exp_half(w2, sel2, 0)});
        end else begin
            @(negedge clk);
            check(!tx_en_o && !done_o && !tx_line_o, "R7", "idle after frame",
                  {tx_en_o, done_o, tx_line_o}, 3'b000);
            check(!done_o, "R5", "done single cycle", done_o, 1'b0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        start_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        start_i = 1'b0;
        check(!tx_line_o && !tx_en_o && !done_o, "R7", "reset state",
              {tx_line_o, tx_en_o, done_o}, 3'b000);
        repeat (3) @(negedge clk);
        check(!tx_line_o && !tx_en_o && !done_o, "R7", "idle without start",
              {tx_line_o, tx_en_o, done_o}, 3'b000);
    endtask

    task automatic t_frame(input logic [15:0] w, input logic sel);
        launch(w, sel);
        collect(w, sel, -1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_ignore(input logic [15:0] w, input logic sel, input int poke);
        launch(w, sel);
        collect(w, sel, poke, 1'b0, '0, 1'b0);
    endtask

    task automatic t_chain();
        logic [39:0] got, exp;
        launch(16'h3A84, 1'b0);
        collect(16'h3A84, 1'b0, -1, 1'b1, 16'hFB82, 1'b1);
        got[0] = tx_line_o;
        exp[0] = exp_half(16'hFB82, 1'b1, 0);
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            got[i] = tx_line_o;
            exp[i] = exp_half(16'hFB82, 1'b1, i);
        end
        check(got == exp, "R9", "second back-to-back frame", got, exp);
        @(negedge clk);
        check(done_o && !tx_en_o, "R9", "done after second frame", {tx_en_o, done_o}, 2'b01);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 50000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_frame(16'hA5A5, 1'b0);
        t_frame(16'h7C12, 1'b1);
        t_frame(16'h0000, 1'b0);
        t_frame(16'hFFFF, 1'b1);
        t_ignore(16'h95A4, 1'b0, 12);
        t_ignore(16'h38A4, 1'b1, 39);
        t_chain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule